// File: doc/BRIEF.md
# Permanent Fault Injection Wrapper

This block sits in the data path of one word of a storage array, such as a register file entry or a rename table slot. It applies a permanent hardware fault model to that word so that resilience experiments can be run against the surrounding logic. Four fault models are available:

- forcing one bit low;
- forcing one bit high;
- a bridging fault on a pair of neighbouring bits that resolves to the AND of the pair;
- the same bridging fault resolving to the OR of the pair.

A small control state machine captures the fault kind and the bit index from a configuration port. It decides whether the setting can be injected when the enable input rises. It then holds that setting unchanged until the enable drops, so the fault stays permanent for the whole run.

Every access presents a word on the input. The word appears on the output one clock later, corrupted when injection is live. A one-cycle pulse marks each access in which the fault changed the word. A saturating counter accumulates those activations. An access in which the fault left the word unchanged is a masked fault and produces no pulse.

The control machine has three states:

- `ST_IDLE`: disarmed, data passes through unchanged, configuration writes are accepted.
- `ST_ARMED`: injecting.
- `ST_REJECT`: the enable is high but the setting cannot be injected, so data passes through unchanged.

It has three transitions:

- `T_ARM_OK`: from `ST_IDLE` to `ST_ARMED`, when the enable is high and the setting is valid.
- `T_ARM_BAD`: from `ST_IDLE` to `ST_REJECT`, when the enable is high and the setting is invalid.
- `T_DISARM`: from `ST_ARMED` or `ST_REJECT` back to `ST_IDLE`, when the enable is low.

Top module: `fi_wrap`

## Requirements
- R1: After reset, `out_data` is 0, `activated` is 0 and `act_count` is 0.
- R2: Fault code 3'b001 (stuck low) with index i forces output bit i to 0 and leaves every other bit unchanged.
- R3: Fault code 3'b010 (stuck high) with index i forces output bit i to 1 and leaves every other bit unchanged.
- R4: Fault code 3'b011 (AND bridge) with index i drives output bits i and i+1 both to the AND of input bits i and i+1. All other bits pass unchanged.
- R5: Fault code 3'b100 (OR bridge) with index i drives output bits i and i+1 both to the OR of input bits i and i+1. All other bits pass unchanged.
- R6: On an access (`acc_valid` high), `out_data` takes the possibly corrupted word one cycle later. In that same cycle, `activated` is high exactly when that word differs from the input word. With no access, `activated` is low and `out_data` holds its value.
- R7: `act_count` increases by one for each activation and stops at 2^CNTW-1.
- R8: Certain settings move the machine to `ST_REJECT` when the enable rises, and the words then pass unchanged with no activation. These settings are code 3'b000, codes 3'b101 to 3'b111, and a bridging code whose index is the top bit (W-1).
- R9: A configuration write (`cfg_we`) takes effect only while the machine is in `ST_IDLE` and `arm` is low. Writes made while armed are dropped and are not applied at the next arming.
- R10: While `arm` is low (machine in `ST_IDLE`), words pass unchanged with no activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Fault code to store |
| cfg_idx | input | $clog2(W) | Bit index to store |
| arm | input | 1 | Injection enable |
| acc_valid | input | 1 | Access strobe for the wrapped word |
| acc_data | input | W | Fault-free word |
| out_data | output | W | Word after the fault, registered |
| activated | output | 1 | Pulse: the fault altered the last word |
| act_count | output | CNTW | Saturating count of activations |

## Verification
Every fault code from 0 to 7 is combined with every bit index and all 256 input words. This full sweep shows that each model touches only its own bit or bit pair, and that a bridge at the top bit is refused. Because every word is applied, it also covers words where the fault is masked, which separates activated faults from masked ones. A short sequence of set, clear and set values moves the counter by exact amounts before the sweep drives it into saturation. Writes issued while armed, and idle cycles with changing input, show that the setting is locked and that the output holds.

// File: rtl/fi_pkg.sv
package fi_pkg;

    typedef enum logic [2:0] {
        F_NONE = 3'b000,
        F_SA0  = 3'b001,
        F_SA1  = 3'b010,
        F_DOM0 = 3'b011,
        F_DOM1 = 3'b100
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_REJECT = 2'd2
    } fi_state_e;

endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
    import fi_pkg::*;
#(
    parameter  int W    = 8,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_kind,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic            arm,
    output logic [2:0]      kind_q,
    output logic [IDXW-1:0] idx_q,
    output fi_state_e       st,
    output logic            inject_en
);

    fi_state_e st_nxt;
    logic      cfg_ok;
    logic      wr_take;

    // Legality of the stored setting
    always_comb begin
        unique case (kind_q)
            F_SA0, F_SA1:   cfg_ok = (int'(idx_q) < W);
            F_DOM0, F_DOM1: cfg_ok = (int'(idx_q) < W - 1);
            default:        cfg_ok = 1'b0;
        endcase
    end

    assign wr_take = cfg_we && !arm && (st == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= F_NONE;
            idx_q  <= '0;
        end else if (wr_take) begin
            kind_q <= cfg_kind;
            idx_q  <= cfg_idx;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Next state: T_ARM_OK, T_ARM_BAD, T_DISARM
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (arm) st_nxt = cfg_ok ? ST_ARMED : ST_REJECT;
            ST_ARMED:  if (!arm) st_nxt = ST_IDLE;
            ST_REJECT: if (!arm) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (st)
            ST_ARMED: inject_en = 1'b1;
            default:  inject_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
    import fi_pkg::*;
#(
    parameter  int W    = 8,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic            en,
    input  logic [2:0]      kind,
    input  logic [IDXW-1:0] idx,
    input  logic [W-1:0]    d,
    output logic [W-1:0]    q,
    output logic            diff
);

    for (genvar j = 0; j < W; j++) begin : g_bit
        logic self_sel;
        logic low_sel;
        logic up_nb;
        logic dn_nb;
        logic qb;

        assign self_sel = en && (idx == IDXW'(j));

        if (j < W - 1) begin : g_up
            assign up_nb = d[j+1];
        end else begin : g_noup
            assign up_nb = 1'b0;
        end

        if (j > 0) begin : g_dn
            assign dn_nb   = d[j-1];
            assign low_sel = en && (idx == IDXW'(j - 1));
        end else begin : g_nodn
            assign dn_nb   = 1'b0;
            assign low_sel = 1'b0;
        end

        always_comb begin
            qb = d[j];
            case (kind)
                F_SA0:  if (self_sel) qb = 1'b0;
                F_SA1:  if (self_sel) qb = 1'b1;
                F_DOM0: begin
                    if (self_sel)     qb = d[j] & up_nb;
                    else if (low_sel) qb = d[j] & dn_nb;
                end
                F_DOM1: begin
                    if (self_sel)     qb = d[j] | up_nb;
                    else if (low_sel) qb = d[j] | dn_nb;
                end
                default: ;
            endcase
        end

        assign q[j] = qb;
    end

    assign diff = |(q ^ d);

endmodule

// File: rtl/fi_tally.sv
module fi_tally #(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bump,
    output logic [CNTW-1:0] count
);

    localparam logic [CNTW-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (bump && count != CMAX) count <= count + 1'b1;
    end

endmodule

// File: rtl/fi_wrap.sv
module fi_wrap
    import fi_pkg::*;
#(
    parameter  int W    = 8,
    parameter  int CNTW = 8,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_kind,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic            arm,
    input  logic            acc_valid,
    input  logic [W-1:0]    acc_data,
    output logic [W-1:0]    out_data,
    output logic            activated,
    output logic [CNTW-1:0] act_count
);

    logic [2:0]      kind_q;
    logic [IDXW-1:0] idx_q;
    fi_state_e       st;
    logic            inject_en;
    logic [W-1:0]    bad_word;
    logic            word_diff;

    fi_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .arm       (arm),
        .kind_q    (kind_q),
        .idx_q     (idx_q),
        .st        (st),
        .inject_en (inject_en)
    );

    fi_corrupt #(.W(W)) u_corrupt (
        .en   (inject_en),
        .kind (kind_q),
        .idx  (idx_q),
        .d    (acc_data),
        .q    (bad_word),
        .diff (word_diff)
    );

    fi_tally #(.CNTW(CNTW)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (acc_valid && word_diff),
        .count (act_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            activated <= 1'b0;
        end else begin
            activated <= acc_valid && word_diff;
            if (acc_valid) out_data <= bad_word;
        end
    end

endmodule

// File: rtl/fi_wrap_chk.sv
module fi_wrap_chk
    import fi_pkg::*;
#(
    parameter  int W    = 8,
    parameter  int CNTW = 8,
    localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [W-1:0]    acc_data,
    input logic [W-1:0]    out_data,
    input logic            activated,
    input logic [CNTW-1:0] act_count,
    input fi_state_e       st,
    input logic [2:0]      kind_q,
    input logic [IDXW-1:0] idx_q
);

    localparam logic [CNTW-1:0] CMAX = '1;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (act_count == '0) && !activated && (out_data == '0));

    a_r6_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !activated);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(out_data));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (act_count == CMAX) |=> (act_count == CMAX));

    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (act_count != CMAX) |=> (act_count == $past(act_count) + CNTW'(activated)));

    // R10 also: a machine that is not armed passes words unchanged
    a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_ARMED && acc_valid) |=> (out_data == $past(acc_data)) && !activated);

    a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(kind_q) && $stable(idx_q));

endmodule

bind fi_wrap fi_wrap_chk #(.W(W), .CNTW(CNTW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_data  (acc_data),
    .out_data  (out_data),
    .activated (activated),
    .act_count (act_count),
    .st        (st),
    .kind_q    (kind_q),
    .idx_q     (idx_q)
);

// File: tb/test_fi_wrap.sv
`timescale 1ns/1ps
module test_fi_wrap;

    localparam int W    = 8;
    localparam int CNTW = 8;
    localparam int CMAX = (1 << CNTW) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_kind = '0;
    logic [2:0]   cfg_idx = '0;
    logic         arm = 1'b0;
    logic         acc_valid = 1'b0;
    logic [W-1:0] acc_data = '0;
    logic [W-1:0] out_data;
    logic         activated;
    logic [CNTW-1:0] act_count;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    fi_wrap #(.W(W), .CNTW(CNTW)) i_fi_wrap (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .arm(arm), .acc_valid(acc_valid), .acc_data(acc_data),
        .out_data(out_data), .activated(activated), .act_count(act_count)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int model(input int kind, input int idx, input int d);
        int m;
        int a;
        int b;
        a = (d >> idx) & 1;
        b = (d >> (idx + 1)) & 1;
        m = 3 << idx;
        case (kind)
            1: return d & ~(1 << idx);
            2: return d | (1 << idx);
            3: if (idx < W - 1) return (a & b) ? (d | m) : (d & ~m);
            4: if (idx < W - 1) return (a | b) ? (d | m) : (d & ~m);
            default: ;
        endcase
        return d;
    endfunction

    function automatic string req_of(input int kind, input int idx);
        if (kind == 1) return "R2";
        if (kind == 2) return "R3";
        if (kind == 3 && idx < W - 1) return "R4";
        if (kind == 4 && idx < W - 1) return "R5";
        return "R8";
    endfunction

    task automatic configure(input int kind, input int idx);
        @(negedge clk); arm = 1'b0;
        @(negedge clk); cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 3'(idx);
        @(negedge clk); cfg_we = 1'b0; arm = 1'b1;
        @(posedge clk);
    endtask

    // Apply one access and check the registered result
    task automatic access(input string req, input int d, input int exp);
        int act;
        @(negedge clk); acc_valid = 1'b1; acc_data = W'(d);
        @(negedge clk); acc_valid = 1'b0;
        act = (exp != d) ? 1 : 0;
        if (act != 0 && exp_cnt < CMAX) exp_cnt++;
        check(req, int'(out_data), exp);
        check({req, "/R6"}, int'(activated), act);
        check("R7", int'(act_count), exp_cnt);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(out_data), 0);
        check("R1", int'(activated), 0);
        check("R1", int'(act_count), 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: disarmed words pass unchanged
        access("R10", 8'hA5, 8'hA5);
        access("R10", 8'h3C, 8'h3C);

        // R7: exact counting, masked access does not bump
        configure(2, 0);
        access("R3", 8'h00, 8'h01);
        access("R3", 8'h01, 8'h01);
        access("R3", 8'h02, 8'h03);
        check("R7", int'(act_count), 2);

        // R6: no access -> no pulse, output holds
        @(negedge clk); acc_data = 8'h55;
        @(negedge clk);
        check("R6", int'(activated), 0);
        check("R6", int'(out_data), 8'h03);

        // R9: write while armed is dropped, also after re-arming
        @(negedge clk); cfg_we = 1'b1; cfg_kind = 3'd1; cfg_idx = 3'd3;
        @(negedge clk); cfg_we = 1'b0;
        access("R9", 8'h00, 8'h01);
        access("R9", 8'hFF, 8'hFF);
        @(negedge clk); arm = 1'b0;
        @(negedge clk); arm = 1'b1;
        @(posedge clk);
        access("R9", 8'h08, 8'h09);

        // Full sweep: every code, every index, every word
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < W; i++) begin
                configure(k, i);
                for (int d = 0; d < (1 << W); d++) begin
                    access(req_of(k, i), d, model(k, i, d));
                end
            end
        end

        check("R7", int'(act_count), CMAX);
        @(negedge clk); arm = 1'b0;
        @(negedge clk);
        access("R10", 8'h81, 8'h81);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule